// File: doc/BRIEF.md
# Data Address Translation and Access Fault Unit

This block turns a data-side virtual address into a physical address, or into a fault, in one registered stage. On each request it gets the address, the access direction, a set of request qualifiers and the privilege context. It also gets the result of an external page-table cache lookup: a hit flag, a frame number, per-mode read and write enables, and fault-on-read and fault-on-write bits. It chooses one of three paths: untranslated pass-through, a fixed kernel-only direct-mapped window, or the looked-up mapping. It then checks the result against the implemented physical width and marks accesses in the uncached half of the physical space.

When a fault is reported, the unit records three things for the fault handler: the faulting address, a packed syndrome word, and a formatted pointer into the linear page table. Requests that are table-walk loads, or that are marked as non-faulting, leave those three registers alone.

Top module: `dtx_unit`

## Requirements
- R1: The mode used for permission checks is `cur_mode` outside privileged code (`in_pal`=0). Inside it, the mode is `alt_mode` when `req_altmode`=1 and kernel otherwise. Mode encoding is 0 kernel, 1 executive, 2 supervisor, 3 user, and mode m is allowed by enable bit m.
- R2: With `req_phys`=1 the address is used unchanged as the physical address. No validity, window, lookup or permission check is made.
- R3: An untranslated request whose address bits 63:47 are not all equal gets fault code 2 with syndrome flags access-violation and bad-address, plus write when writing. This check comes before every other check.
- R4: A valid address with bits 47:41 equal to 0x7E uses the direct window and ignores the lookup result. If `cur_mode` (the raw input, not the PAL-adjusted mode) is not kernel, the result is fault code 1 with flags access-violation, plus write when writing.
- R5: In the window, the physical address is the low 44 address bits. If bit 40 is set, bits 43:40 are forced to ones; otherwise bits 43:41 are cleared.
- R6: An untranslated, non-window request without a lookup hit gets the miss flag, plus write when writing. The fault code is 4 when `req_vpte`=1 and 3 otherwise.
- R7: On a hit, the physical address is the frame number shifted left by 13, ORed with address bits 12:0.
- R8: A write without its mode's write enable gets code 2 with flags write and access-violation, plus fault-on-write if that bit is set. A permitted write with fault-on-write set gets code 2 with flags write and fault-on-write. A read without its read enable gets code 1 with access-violation, plus fault-on-read if set. A permitted read with fault-on-read gets code 2 with fault-on-read.
- R9: On every fault with codes 1 to 4, `flt_va` takes the address. `flt_stat` takes opcode in bits 16:11, RA in bits 10:6 and flags in bits 5:0: write=0, access-violation=1, bad-address=2, miss=3, fault-on-read=4, fault-on-write=5. `flt_form` takes `ptbr` ORed with address bits 47:13 shifted left by 3.
- R10: The three fault registers keep their value for requests with `req_vpte` or `req_nofault` set, for machine checks, and for fault-free requests.
- R11: If no other fault occurred and the physical address has any bit at or above 44 set, the fault code is 5 (machine check).
- R12: If physical bit 43 is set on a fault-free result, `rsp_uncached` is 1 and bits 42:35 of `rsp_pa` are cleared.
- R13: Results appear one clock after the request. On any fault `rsp_pa` and `rsp_uncached` are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Untranslated request |
| req_altmode | input | 1 | Use alternate mode when in privileged code |
| req_vpte | input | 1 | Page-table walk load |
| req_nofault | input | 1 | Do not record faults |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| in_pal | input | 1 | Executing privileged code |
| inst_opc | input | 6 | Opcode of the access instruction |
| inst_ra | input | 5 | RA field of the access instruction |
| ptbr | input | 64 | Linear page table base |
| tlb_hit | input | 1 | Lookup hit |
| tlb_pfn | input | 32 | Frame number on a hit |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fault_rd | input | 1 | Fault-on-read bit |
| tlb_fault_wr | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Uncached access |
| rsp_fault | output | 3 | Fault code: 0 none, 1 access violation, 2 translation fault, 3 data miss, 4 walk miss, 5 machine check |
| flt_va | output | 64 | Faulting address |
| flt_stat | output | 17 | Fault syndrome |
| flt_form | output | 64 | Formatted page-table pointer |

## Verification
The assertions check four behaviours on every cycle. Pass-through requests inside the implemented range return their address with no fault. Non-kernel window requests always report an access violation. Misses on low canonical addresses report the code chosen by the walk flag. The fault registers never move after a walk or non-faulting request. The output form of uncached addresses is also checked on every cycle. Only the directed scenarios can show the exact syndrome packing, the window sign extension, the priority among faults on one request, the PAL mode substitution and the machine check on oversized frames, because each depends on specific address values.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_EXEC = 2'd1,
      MODE_SUPV = 2'd2,
      MODE_USER = 2'd3
   } priv_mode_e;

   typedef enum logic [2:0] {
      FC_NONE      = 3'd0,
      FC_ACCESS    = 3'd1,
      FC_TRANS     = 3'd2,
      FC_MISS_DATA = 3'd3,
      FC_MISS_PTE  = 3'd4,
      FC_MCHK      = 3'd5
   } fault_code_e;

   localparam int OPC_W  = 6;
   localparam int RA_W   = 5;
   localparam int FLAG_W = 6;
   localparam int STAT_W = OPC_W + RA_W + FLAG_W;

   // syndrome flag positions, decoded by the fault handler
   localparam int SB_WRITE = 0;
   localparam int SB_ACV   = 1;
   localparam int SB_BADVA = 2;
   localparam int SB_MISS  = 3;
   localparam int SB_FONR  = 4;
   localparam int SB_FONW  = 5;
endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel (
   input  logic       in_pal,
   input  logic       use_alt,
   input  logic [1:0] cur_mode,
   input  logic [1:0] alt_mode,
   output logic [1:0] eff_mode
);
   import dtx_pkg::*;

   always_comb begin
      if (!in_pal)      eff_mode = cur_mode;
      else if (use_alt) eff_mode = alt_mode;
      else              eff_mode = MODE_KERN;
   end
endmodule

// File: rtl/dtx_addr_path.sv
module dtx_addr_path #(
   parameter int VA_W         = 64,
   parameter int VA_SIG       = 48,
   parameter int PA_W         = 44,
   parameter int PAGE_BITS    = 13,
   parameter int PFN_W        = 32,
   parameter int UC_CLR_LO    = 35,
   parameter bit CLR_UC_FIELD = 1'b1,
   parameter logic [VA_SIG-PA_W+2:0] SP_TAG = 7'h7E
) (
   input  logic [VA_W-1:0]  va,
   input  logic             phys,
   input  logic [PFN_W-1:0] pfn,
   output logic             sp_win,
   output logic             mchk,
   output logic [PA_W-1:0]  pa_out,
   output logic             uc
);
   localparam int UC_BIT = PA_W - 1;
   localparam int SX_BIT = PA_W - 4;
   localparam int SP_HI  = VA_SIG - 1;
   localparam int SP_LO  = SX_BIT + 1;
   localparam int HIT_PAD = VA_W - PFN_W - PAGE_BITS;

   logic [PA_W-1:0] sp_pa;
   logic [VA_W-1:0] hit_pa;
   logic [VA_W-1:0] raw_pa;

   assign sp_win = (va[SP_HI:SP_LO] == SP_TAG);

   always_comb begin
      sp_pa = va[PA_W-1:0];
      if (va[SX_BIT]) sp_pa[PA_W-1:SX_BIT]   = '1;
      else            sp_pa[PA_W-1:SX_BIT+1] = '0;
   end

   assign hit_pa = {{HIT_PAD{1'b0}}, pfn, va[PAGE_BITS-1:0]};

   always_comb begin
      if (phys)        raw_pa = va;
      else if (sp_win) raw_pa = {{(VA_W-PA_W){1'b0}}, sp_pa};
      else             raw_pa = hit_pa;
   end

   assign mchk = |raw_pa[VA_W-1:PA_W];
   assign uc   = raw_pa[UC_BIT];

   generate
      if (CLR_UC_FIELD) begin : g_clr_uc
         always_comb begin
            pa_out = raw_pa[PA_W-1:0];
            if (raw_pa[UC_BIT]) pa_out[UC_BIT-1:UC_CLR_LO] = '0;
         end
      end else begin : g_keep_uc
         assign pa_out = raw_pa[PA_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dtx_fault_eval.sv
module dtx_fault_eval #(
   parameter int HI_W = 17
) (
   input  logic            phys,
   input  logic [HI_W-1:0] va_hi,
   input  logic            sp_win,
   input  logic [1:0]      cur_mode,
   input  logic [1:0]      eff_mode,
   input  logic            write,
   input  logic            vpte,
   input  logic            hit,
   input  logic [3:0]      rd_en,
   input  logic [3:0]      wr_en,
   input  logic            f_on_rd,
   input  logic            f_on_wr,
   input  logic            mchk,
   output logic [2:0]      fcode,
   output logic [dtx_pkg::FLAG_W-1:0] flags,
   output logic            report
);
   import dtx_pkg::*;

   fault_code_e fc;
   logic        bad_va;

   assign bad_va = !((&va_hi) || !(|va_hi));

   always_comb begin
      fc    = FC_NONE;
      flags = '0;
      if (!phys) begin
         if (bad_va) begin
            fc = FC_TRANS;
            flags[SB_WRITE] = write;
            flags[SB_ACV]   = 1'b1;
            flags[SB_BADVA] = 1'b1;
         end else if (sp_win) begin
            if (cur_mode != MODE_KERN) begin
               fc = FC_ACCESS;
               flags[SB_WRITE] = write;
               flags[SB_ACV]   = 1'b1;
            end
         end else if (!hit) begin
            fc = vpte ? FC_MISS_PTE : FC_MISS_DATA;
            flags[SB_WRITE] = write;
            flags[SB_MISS]  = 1'b1;
         end else if (write) begin
            if (!wr_en[eff_mode]) begin
               fc = FC_TRANS;
               flags[SB_WRITE] = 1'b1;
               flags[SB_ACV]   = 1'b1;
               flags[SB_FONW]  = f_on_wr;
            end else if (f_on_wr) begin
               fc = FC_TRANS;
               flags[SB_WRITE] = 1'b1;
               flags[SB_FONW]  = 1'b1;
            end
         end else begin
            if (!rd_en[eff_mode]) begin
               fc = FC_ACCESS;
               flags[SB_ACV]  = 1'b1;
               flags[SB_FONR] = f_on_rd;
            end else if (f_on_rd) begin
               fc = FC_TRANS;
               flags[SB_FONR] = 1'b1;
            end
         end
      end
      report = (fc != FC_NONE);
      if (fc == FC_NONE && mchk) fc = FC_MCHK;
   end

   assign fcode = fc;
endmodule

// File: rtl/dtx_unit.sv
module dtx_unit #(
   parameter int VA_W         = 64,
   parameter int VA_SIG       = 48,
   parameter int PA_W         = 44,
   parameter int PAGE_BITS    = 13,
   parameter int PFN_W        = 32,
   parameter int UC_CLR_LO    = 35,
   parameter bit CLR_UC_FIELD = 1'b1,
   parameter logic [VA_SIG-PA_W+2:0] SP_TAG = 7'h7E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic             req_phys,
   input  logic             req_altmode,
   input  logic             req_vpte,
   input  logic             req_nofault,
   input  logic [1:0]       cur_mode,
   input  logic [1:0]       alt_mode,
   input  logic             in_pal,
   input  logic [5:0]       inst_opc,
   input  logic [4:0]       inst_ra,
   input  logic [VA_W-1:0]  ptbr,
   input  logic             tlb_hit,
   input  logic [PFN_W-1:0] tlb_pfn,
   input  logic [3:0]       tlb_rd_en,
   input  logic [3:0]       tlb_wr_en,
   input  logic             tlb_fault_rd,
   input  logic             tlb_fault_wr,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_uncached,
   output logic [2:0]       rsp_fault,
   output logic [VA_W-1:0]  flt_va,
   output logic [16:0]      flt_stat,
   output logic [VA_W-1:0]  flt_form
);
   import dtx_pkg::*;

   localparam int HI_W   = VA_W - VA_SIG + 1;
   localparam int VPN_W  = VA_SIG - PAGE_BITS;
   localparam int FORM_PAD = VA_W - VPN_W - 3;
   localparam int UC_BIT = PA_W - 1;
   localparam int SP_HI  = VA_SIG - 1;
   localparam int SP_LO  = PA_W - 3;

   initial begin
      assert (VA_W >= PFN_W + PAGE_BITS) else $error("frame does not fit the address");
      assert (VA_SIG > PA_W && VA_SIG < VA_W) else $error("bad significant VA width");
      assert (UC_CLR_LO > PAGE_BITS && UC_CLR_LO < UC_BIT) else $error("bad uncached field");
      assert (STAT_W == 17) else $error("syndrome width mismatch");
   end

   logic [1:0]        eff_mode;
   logic              sp_win, mchk, uc, report;
   logic [PA_W-1:0]   pa_c;
   logic [2:0]        fcode;
   logic [FLAG_W-1:0] flags;
   logic [VA_W-1:0]   vpn_sh;

   dtx_mode_sel u_mode (
      .in_pal   (in_pal),
      .use_alt  (req_altmode),
      .cur_mode (cur_mode),
      .alt_mode (alt_mode),
      .eff_mode (eff_mode)
   );

   dtx_addr_path #(
      .VA_W(VA_W), .VA_SIG(VA_SIG), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
      .PFN_W(PFN_W), .UC_CLR_LO(UC_CLR_LO), .CLR_UC_FIELD(CLR_UC_FIELD),
      .SP_TAG(SP_TAG)
   ) u_addr (
      .va     (req_va),
      .phys   (req_phys),
      .pfn    (tlb_pfn),
      .sp_win (sp_win),
      .mchk   (mchk),
      .pa_out (pa_c),
      .uc     (uc)
   );

   dtx_fault_eval #(.HI_W(HI_W)) u_fault (
      .phys     (req_phys),
      .va_hi    (req_va[VA_W-1:VA_SIG-1]),
      .sp_win   (sp_win),
      .cur_mode (cur_mode),
      .eff_mode (eff_mode),
      .write    (req_write),
      .vpte     (req_vpte),
      .hit      (tlb_hit),
      .rd_en    (tlb_rd_en),
      .wr_en    (tlb_wr_en),
      .f_on_rd  (tlb_fault_rd),
      .f_on_wr  (tlb_fault_wr),
      .mchk     (mchk),
      .fcode    (fcode),
      .flags    (flags),
      .report   (report)
   );

   assign vpn_sh = {{FORM_PAD{1'b0}}, req_va[VA_SIG-1:PAGE_BITS], 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_pa       <= '0;
         rsp_uncached <= 1'b0;
         rsp_fault    <= FC_NONE;
         flt_va       <= '0;
         flt_stat     <= '0;
         flt_form     <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault    <= fcode;
            rsp_pa       <= (fcode == FC_NONE) ? pa_c : '0;
            rsp_uncached <= (fcode == FC_NONE) && uc;
            if (report && !req_vpte && !req_nofault) begin
               flt_va   <= req_va;
               flt_stat <= {inst_opc, inst_ra, flags};
               flt_form <= ptbr | vpn_sh;
            end
         end
      end
   end

   // pass-through inside the implemented range returns the address unchanged
   assert_phys_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_phys && (req_va[VA_W-1:PA_W] == '0) && !req_va[UC_BIT]
      |=> (rsp_fault == FC_NONE) && (rsp_pa == $past(req_va[PA_W-1:0])));

   // window access outside kernel mode always violates access
   assert_sp_kernel_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_phys && (&req_va[VA_W-1:VA_SIG-1]) &&
      (req_va[SP_HI:SP_LO] == SP_TAG) && (cur_mode != MODE_KERN)
      |=> rsp_fault == FC_ACCESS);

   // a miss on a low canonical address reports the walk-dependent code
   assert_miss_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_phys && !tlb_hit && (req_va[VA_W-1:VA_SIG-1] == '0)
      |=> rsp_fault == ($past(req_vpte) ? FC_MISS_PTE : FC_MISS_DATA));

   // walk and non-faulting requests never disturb the fault registers
   assert_quiet_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_vpte || req_nofault)
      |=> $stable(flt_va) && $stable(flt_stat) && $stable(flt_form));

   generate
      if (CLR_UC_FIELD) begin : g_uc_chk
         assert_uc_field_R12: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_uncached |-> rsp_pa[UC_BIT] && (rsp_pa[UC_BIT-1:UC_CLR_LO] == '0));
      end
   endgenerate
endmodule

// File: tb/dtx_unit_tb.sv
`timescale 1ns/1ps
module dtx_unit_tb;
   localparam logic [63:0] PTBR = 64'h0000_4000_0000_0000;
   localparam int F_NONE = 0, F_ACC = 1, F_TRANS = 2, F_MISS = 3, F_MPTE = 4, F_MCHK = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid, req_write, req_phys, req_altmode, req_vpte, req_nofault;
   logic [63:0] req_va;
   logic [1:0]  cur_mode, alt_mode;
   logic        in_pal;
   logic [5:0]  inst_opc;
   logic [4:0]  inst_ra;
   logic [63:0] ptbr;
   logic        tlb_hit, tlb_fault_rd, tlb_fault_wr;
   logic [31:0] tlb_pfn;
   logic [3:0]  tlb_rd_en, tlb_wr_en;
   logic        rsp_valid, rsp_uncached;
   logic [43:0] rsp_pa;
   logic [2:0]  rsp_fault;
   logic [63:0] flt_va, flt_form;
   logic [16:0] flt_stat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dtx_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .req_phys(req_phys), .req_altmode(req_altmode),
      .req_vpte(req_vpte), .req_nofault(req_nofault), .cur_mode(cur_mode),
      .alt_mode(alt_mode), .in_pal(in_pal), .inst_opc(inst_opc), .inst_ra(inst_ra),
      .ptbr(ptbr), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_rd_en(tlb_rd_en),
      .tlb_wr_en(tlb_wr_en), .tlb_fault_rd(tlb_fault_rd), .tlb_fault_wr(tlb_fault_wr),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
      .rsp_fault(rsp_fault), .flt_va(flt_va), .flt_stat(flt_stat), .flt_form(flt_form)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_req();
      req_valid = 0; req_write = 0; req_phys = 0; req_altmode = 0;
      req_vpte = 0; req_nofault = 0; req_va = '0; cur_mode = 0; alt_mode = 0;
      in_pal = 0; inst_opc = 0; inst_ra = 0; ptbr = PTBR; tlb_hit = 0;
      tlb_pfn = 0; tlb_rd_en = 0; tlb_wr_en = 0; tlb_fault_rd = 0; tlb_fault_wr = 0;
   endtask

   // one request: launched at a falling edge, sampled one full cycle later
   task automatic fire();
      req_valid = 1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic t_reset();
      chk("R13 reset valid", rsp_valid, 0);
      chk("R13 reset pa", rsp_pa, 0);
      chk("R13 reset fault", rsp_fault, 0);
      chk("R13 reset stat", flt_stat, 0);
      chk("R13 reset form", flt_form, 0);
   endtask

   task automatic t_phys();
      clear_req(); req_phys = 1; cur_mode = 3; req_va = 64'h0000_0123_4567_89AB;
      fire();
      chk("R2 phys pa", rsp_pa, 44'h123_4567_89AB);
      chk("R2 phys fault", rsp_fault, F_NONE);
      chk("R13 phys valid", rsp_valid, 1);
      chk("R12 phys cached", rsp_uncached, 0);
   endtask

   task automatic t_uncache();
      clear_req(); req_phys = 1; req_va = 64'h0000_08FF_2345_6789;
      fire();
      chk("R12 uc pa", rsp_pa, 44'h807_2345_6789);
      chk("R12 uc flag", rsp_uncached, 1);
   endtask

   task automatic t_badva();
      clear_req(); req_write = 1; cur_mode = 3; inst_opc = 6'h2D; inst_ra = 5'h1F;
      req_va = 64'h0001_0000_0000_0000;
      fire();
      chk("R3 badva fault", rsp_fault, F_TRANS);
      chk("R3 R9 badva stat", flt_stat, 17'h16FC7);
      chk("R9 badva va", flt_va, 64'h0001_0000_0000_0000);
      chk("R9 badva form", flt_form, PTBR);
      chk("R13 fault pa zero", rsp_pa, 0);
   endtask

   task automatic t_mchk_phys();
      clear_req(); req_phys = 1; inst_opc = 6'h11; req_va = 64'h0000_1000_0000_0000;
      fire();
      chk("R11 phys mchk", rsp_fault, F_MCHK);
      chk("R10 mchk keeps stat", flt_stat, 17'h16FC7);
      chk("R10 mchk keeps va", flt_va, 64'h0001_0000_0000_0000);
   endtask

   task automatic t_sp_kernel();
      clear_req(); req_va = 64'hFFFF_FC12_3456_7890;
      fire();
      chk("R4 sp no tlb fault", rsp_fault, F_NONE);
      chk("R5 sp pa low", rsp_pa, 44'h012_3456_7890);
      chk("R5 sp cached", rsp_uncached, 0);
   endtask

   task automatic t_sp_sext();
      clear_req(); req_va = 64'hFFFF_FD00_0345_6000;
      fire();
      chk("R5 R12 sp sext pa", rsp_pa, 44'h800_0345_6000);
      chk("R12 sp uc", rsp_uncached, 1);
   endtask

   task automatic t_sp_user();
      clear_req(); cur_mode = 3; inst_opc = 6'h29; inst_ra = 5'h05;
      req_va = 64'hFFFF_FC00_0000_2000;
      fire();
      chk("R4 sp user fault", rsp_fault, F_ACC);
      chk("R9 sp user stat", flt_stat, 17'h14942);
      chk("R9 sp user va", flt_va, 64'hFFFF_FC00_0000_2000);
      chk("R9 sp user form", flt_form, 64'h0000_403F_0000_0008);
      clear_req(); cur_mode = 3; in_pal = 1; req_va = 64'hFFFF_FC00_0000_2000;
      fire();
      chk("R4 sp uses raw mode in pal", rsp_fault, F_ACC);
   endtask

   task automatic t_miss();
      clear_req(); inst_opc = 6'h28; inst_ra = 5'h02; req_va = 64'h4010;
      fire();
      chk("R6 miss code", rsp_fault, F_MISS);
      chk("R6 R9 miss stat", flt_stat, 17'h14088);
      chk("R9 miss form", flt_form, PTBR | 64'h10);
      chk("R9 miss va", flt_va, 64'h4010);
   endtask

   task automatic t_miss_pte();
      clear_req(); req_vpte = 1; req_write = 1; inst_opc = 6'h3F; req_va = 64'h8000;
      fire();
      chk("R6 walk miss code", rsp_fault, F_MPTE);
      chk("R10 walk keeps stat", flt_stat, 17'h14088);
      chk("R10 walk keeps va", flt_va, 64'h4010);
      chk("R10 walk keeps form", flt_form, PTBR | 64'h10);
   endtask

   task automatic t_nofault();
      clear_req(); req_nofault = 1; inst_opc = 6'h3F; req_va = 64'hA000;
      fire();
      chk("R6 nofault miss code", rsp_fault, F_MISS);
      chk("R10 nofault keeps stat", flt_stat, 17'h14088);
      chk("R10 nofault keeps va", flt_va, 64'h4010);
   endtask

   task automatic t_hit();
      clear_req(); tlb_hit = 1; tlb_pfn = 32'h1234; tlb_rd_en = 4'b0001; req_va = 64'h7ABC;
      fire();
      chk("R7 hit pa", rsp_pa, 44'h246_9ABC);
      chk("R7 hit fault", rsp_fault, F_NONE);
      chk("R10 clean hit keeps va", flt_va, 64'h4010);
   endtask

   task automatic t_perm();
      clear_req(); tlb_hit = 1; cur_mode = 3; req_va = 64'h2000; req_write = 1;
      tlb_wr_en = 4'b0111; tlb_fault_wr = 1;
      fire();
      chk("R8 wr deny fault", rsp_fault, F_TRANS);
      chk("R8 wr deny stat", flt_stat, 17'h23);
      tlb_wr_en = 4'b1000;
      fire();
      chk("R8 fow fault", rsp_fault, F_TRANS);
      chk("R8 fow stat", flt_stat, 17'h21);
      req_write = 0; tlb_rd_en = 4'b0111; tlb_fault_rd = 1;
      fire();
      chk("R8 rd deny fault", rsp_fault, F_ACC);
      chk("R8 rd deny stat", flt_stat, 17'h12);
      tlb_rd_en = 4'b1000;
      fire();
      chk("R8 for fault", rsp_fault, F_TRANS);
      chk("R8 for stat", flt_stat, 17'h10);
      tlb_fault_rd = 0; tlb_wr_en = 4'b0000;
      fire();
      chk("R8 read ok ignores write bits", rsp_fault, F_NONE);
   endtask

   task automatic t_pal();
      clear_req(); tlb_hit = 1; tlb_rd_en = 4'b0001; cur_mode = 3; req_va = 64'h2000;
      in_pal = 1;
      fire();
      chk("R1 pal kernel", rsp_fault, F_NONE);
      req_altmode = 1; alt_mode = 3;
      fire();
      chk("R1 pal alt user", rsp_fault, F_ACC);
      chk("R1 pal alt stat", flt_stat, 17'h02);
      alt_mode = 0;
      fire();
      chk("R1 pal alt kernel", rsp_fault, F_NONE);
      tlb_rd_en = 4'b0100; alt_mode = 2;
      fire();
      chk("R1 pal alt super", rsp_fault, F_NONE);
      in_pal = 0;
      fire();
      chk("R1 outside pal user", rsp_fault, F_ACC);
   endtask

   task automatic t_hit_mchk();
      clear_req(); tlb_hit = 1; tlb_rd_en = 4'b1111; tlb_pfn = 32'hFFFF_FFFF; req_va = 64'h0;
      fire();
      chk("R11 hit mchk", rsp_fault, F_MCHK);
      chk("R13 mchk pa zero", rsp_pa, 0);
   endtask

   initial begin
      clear_req();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_phys();
      t_uncache();
      t_badva();
      t_mchk_phys();
      t_sp_kernel();
      t_sp_sext();
      t_sp_user();
      t_miss();
      t_miss_pte();
      t_nofault();
      t_hit();
      t_perm();
      t_pal();
      t_hit_mchk();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule